// File: doc/BRIEF.md
# Cascadable Serial Bitstream Store

This block is a bit-serial read-only store for a configuration bitstream. A downstream loader supplies the clock; each rising edge moves an internal bit address forward and the next stored bit appears on a serial data line. The loader samples that bit on its following rising edge. The data line is released to high impedance whenever the store is not selected, is in reset, or has already sent its last bit.

One input pin has two jobs. At its active level it resets the store. At its other level it enables the output. A parameter chooses which level counts as active, so the store can work with loaders that use either polarity. Once the last bit has gone out, an active-low cascade output asserts. That output can drive the chip enable of a second store that shares the same clock and data line, so several stores read back as one long stream.

A one-bit load port fills the storage array while the block is held in reset. The array depth is a parameter.

Top module: `serial_bitstore`

## Requirements
- R1: When a rising clock edge arrives with `ce_n` low and the reset pin at its inactive level, the bit address advances by one. When `ce_n` is high, the address does not change.
- R2: While `ce_n` is high (standby), `sdata_en` is 0 and `sdata` is high impedance, whatever level `rst_oe` has.
- R3: While `rst_oe` is at its active level, the address is zero and the output is released. The active level is high when `RST_ACTIVE_HIGH` = 1 and low when it is 0. The address is cleared as soon as the pin reaches that level, without waiting for a clock edge, and reading restarts from bit 0 after the pin is released.
- R4: While driving (`sdata_en` = 1), `sdata` shows the stored bit at the current address. Bits go out from address 0 upward, and the bit at address k appears after the k-th advancing edge following reset.
- R5: After DEPTH advancing edges, `cas_n` goes to 0, the output is released and the address stops moving. `cas_n` stays at 0 until reset.
- R6: While the reset pin is active, each cycle with `ld_en` = 1 writes `ld_bit` to the next array address. The load address starts at 0 and returns to 0 whenever `ld_en` is low or reset is inactive. When reset is inactive, `ld_en` has no effect on the stored bits.
- R7: Two stores can share the clock and data line, with the second store's `ce_n` driven by the first store's `cas_n`. They then produce the first store's bits followed by the second store's bits, and the two never drive the line at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock supplied by the loader |
| ce_n | input | 1 | Active-low chip enable; when high, the store is in standby |
| rst_oe | input | 1 | Combined reset and output-enable pin; its active level is set by `RST_ACTIVE_HIGH` |
| ld_en | input | 1 | Load strobe; accepted only while in reset |
| ld_bit | input | 1 | Bit to be written by the load port |
| sdata | output | 1 | Serial data; high impedance when not driving |
| sdata_en | output | 1 | Drive enable that goes with `sdata` |
| cas_n | output | 1 | Active-low cascade enable for the next store |

## Verification
The hardest situation to reach is the handoff on a shared line. It needs a full image to be streamed out, the first store to release the line on the exact edge where the second store picks it up, and the second store to keep its own position through a reset of the first store. The bench builds two instances: the first has an active-high reset pin and the second an active-low one, with the second enabled by the first's cascade output. The stimulus drives both stores through the handoff. It also pauses mid-stream, applies an asynchronous reset to each store separately, and reloads only part of an image, so that the expected stream mixes new and old bits.

// File: rtl/serial_bitstore.sv
module serial_bitstore #(
  parameter int DEPTH           = 2048,
  parameter bit RST_ACTIVE_HIGH = 1'b1,
  localparam int AW             = $clog2(DEPTH + 1),
  localparam int IW             = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic ce_n,
  input  logic rst_oe,
  input  logic ld_en,
  input  logic ld_bit,
  output logic sdata,
  output logic sdata_en,
  output logic cas_n
);

  localparam logic [AW-1:0] END_ADDR = AW'(DEPTH);

  logic             rst_act;
  logic [DEPTH-1:0] store;
  logic [AW-1:0]    addr;
  logic [IW-1:0]    ld_ptr;
  logic             done;
  logic             drive;

  assign rst_act = RST_ACTIVE_HIGH ? rst_oe : ~rst_oe;
  assign done    = (addr == END_ADDR);
  assign drive   = ~ce_n & ~rst_act & ~done;

  always_ff @(posedge clk or posedge rst_act) begin
    if (rst_act)    addr <= '0;
    else if (drive) addr <= addr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_act && ld_en) begin
      store[ld_ptr] <= ld_bit;
      ld_ptr        <= ld_ptr + 1'b1;
    end else begin
      ld_ptr        <= '0;
    end
  end

  assign sdata_en = drive;
  assign sdata    = drive ? store[addr[IW-1:0]] : 1'bz;
  assign cas_n    = ~done;

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst_act)
    ce_n |=> $stable(addr));

  assert_step_R1: assert property (@(posedge clk) disable iff (rst_act)
    (!ce_n && cas_n) |=> (addr == AW'($past(addr) + 1)));

  assert_standby_R2: assert property (@(posedge clk) disable iff (rst_act)
    ce_n |-> !sdata_en);

  assert_cas_sticky_R5: assert property (@(posedge clk) disable iff (rst_act)
    !cas_n |=> (!cas_n && $stable(addr)));

  assert_cas_after_last_R5: assert property (@(posedge clk) disable iff (rst_act)
    $fell(cas_n) |-> ($past(addr) == END_ADDR - 1'b1));

  assert_quiet_after_end_R5: assert property (@(posedge clk) disable iff (rst_act)
    !cas_n |-> !sdata_en);

  assert_load_ignored_R6: assert property (@(posedge clk) disable iff (rst_act)
    ld_en |=> $stable(store));

endmodule

// File: tb/serial_bitstore_bench.sv
`timescale 1ns/100ps
module serial_bitstore_bench;
  localparam int D = 16;

  typedef struct {
    bit    en_a, val_a, cas_a, en_b, val_b, cas_b, line;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic ce_n = 1'b1, rst_a = 1'b1, rst_b = 1'b0;
  logic lda_en = 1'b0, lda_bit = 1'b0, ldb_en = 1'b0, ldb_bit = 1'b0;
  logic sd_a, en_a, cas_a, sd_b, en_b, cas_b;

  serial_bitstore #(.DEPTH(D), .RST_ACTIVE_HIGH(1'b1)) u_serial_bitstore (
    .clk(clk), .ce_n(ce_n), .rst_oe(rst_a), .ld_en(lda_en), .ld_bit(lda_bit),
    .sdata(sd_a), .sdata_en(en_a), .cas_n(cas_a));

  serial_bitstore #(.DEPTH(D), .RST_ACTIVE_HIGH(1'b0)) u_serial_bitstore_next (
    .clk(clk), .ce_n(cas_a), .rst_oe(rst_b), .ld_en(ldb_en), .ld_bit(ldb_bit),
    .sdata(sd_b), .sdata_en(en_b), .cas_n(cas_b));

  int   nchk = 0, nfail = 0;
  exp_t q[$];
  logic [D-1:0] img_a = '0, img_b = '0;
  int   ma = 0, mb = 0, lpa = 0, lpb = 0;

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(bit ce, bit ra, bit rb, bit la, bit lab, bit lb, bit lbb, string tag);
    exp_t e;
    bit   ra_act, rb_act;
    @(negedge clk);
    ce_n = ce; rst_a = ra; rst_b = rb;
    lda_en = la; lda_bit = lab; ldb_en = lb; ldb_bit = lbb;
    ra_act = ra;
    rb_act = !rb;
    if (ra_act) ma = 0;
    if (rb_act) mb = 0;
    e.cas_a = (ma != D);
    e.en_a  = !ce && !ra_act && (ma < D);
    e.val_a = e.en_a ? img_a[ma] : 1'b0;
    e.cas_b = (mb != D);
    e.en_b  = !e.cas_a && !rb_act && (mb < D);
    e.val_b = e.en_b ? img_b[mb] : 1'b0;
    e.line  = e.en_a ? e.val_a : (e.en_b ? e.val_b : 1'b1);
    e.tag   = tag;
    q.push_back(e);
    if (ra_act && la) begin img_a[lpa] = lab; lpa = (lpa + 1) % D; end else lpa = 0;
    if (rb_act && lb) begin img_b[lpb] = lbb; lpb = (lpb + 1) % D; end else lpb = 0;
    if (e.en_a) ma++;
    if (e.en_b) mb++;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        bit   line;
        e = q.pop_front();
        line = en_a ? sd_a : (en_b ? sd_b : 1'b1);
        chk(e.tag, "en_a", en_a, e.en_a);
        chk(e.tag, "cas_a", cas_a, e.cas_a);
        chk(e.tag, "en_b", en_b, e.en_b);
        chk(e.tag, "cas_b", cas_b, e.cas_b);
        if (e.en_a) chk(e.tag, "sdata_a", sd_a, e.val_a);
        if (e.en_b) chk(e.tag, "sdata_b", sd_b, e.val_b);
        chk(e.tag, "line", line, e.line);
        chk({e.tag, " R7"}, "single driver", int'(en_a && en_b), 0);
      end
    end
  end

  initial begin : watchdog
    #(50000 * 5);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin : stimulus
    logic [D-1:0] pat_a = 16'hB4C9, pat_b = 16'h5A3E;
    repeat (2) cyc(1, 1, 0, 0, 0, 0, 0, "R3 reset state");
    for (int i = 0; i < D; i++) cyc(1, 1, 0, 1, pat_a[i], 1, pat_b[i], "R6 load");
    cyc(1, 1, 0, 0, 0, 0, 0, "R3 held");
    repeat (3) cyc(1, 0, 1, 0, 0, 0, 0, "R2 standby");
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1, ~pat_a[i], 1, 1'b1, "R4 stream, R6 stray load");
    repeat (2) cyc(1, 0, 1, 0, 0, 0, 0, "R1 hold");
    repeat (D - 5 + D + 4) cyc(0, 0, 1, 0, 0, 0, 0, "R7 chain, R5 end");
    cyc(0, 1, 1, 0, 0, 0, 0, "R3 reset first only");
    repeat (3) cyc(0, 0, 1, 0, 0, 0, 0, "R4 restart, R5 second held");
    cyc(1, 1, 0, 0, 0, 0, 0, "R3 both reset");
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 1, ~pat_a[i], 0, 0, "R6 partial reload");
    cyc(1, 1, 0, 0, 0, 0, 0, "R6 reload end");
    repeat (D + 6) cyc(0, 0, 1, 0, 0, 0, 0, "R6 mixed image, R7 handoff");
    cyc(0, 0, 0, 0, 0, 0, 0, "R3 active-low reset");
    repeat (D + 4) cyc(0, 0, 1, 0, 0, 0, 0, "R3 second restart, R5");
    repeat (3) @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule